// File: doc/BRIEF.md
# Interrupt Aggregator with Deassertion Hold-off

This block gathers many internal event sources into one host interrupt line. Four sources are "direct": each has a sticky bit in the top status register that software clears there. Three come from hardware event pulses, and the fourth is a software request. Six more sources are "cascaded". The status register only mirrors the level of each cascaded sub-module line, and the bit goes away only once software clears the condition at its origin. A mask register enables each source on its own. The OR of the enabled, pending bits requests the interrupt.

A configuration register holds four controls for the output line: the output enable, the polarity and the buffer type (push-pull or open-drain, so the line can be shared). It also holds an 8-bit hold-off field that sets a minimum time for which the line must stay deasserted. The hold-off starts on every deassertion of the line, whatever its cause, and lasts field × 16 clocks. A field of zero disables it. A separate power-event output bypasses the hold-off completely.

The register port is a plain synchronous port. Address 0 is the status register, address 1 the mask, address 2 the configuration, and address 3 reads as zero. The read data is combinational from the address.

Top module: `irq_combiner`

## Requirements
- R1: Status bits 0..2 are set by a one-cycle high pulse on `dir_evt[0..2]` and stay set until a status write with a 1 in that bit position. A pulse in the same cycle as a clearing write leaves the bit set. The bits reset to 0.
- R2: Status bits 4..9 show the current level of `casc_lvl[0..5]`. Status writes have no effect on them.
- R3: The mask register (address 1, bits 9..0) gates the status bit at the same position. The logical interrupt becomes active one clock after an enabled, pending bit is present, provided no hold-off is running. It becomes inactive one clock after no enabled bit is pending.
- R4: Configuration bit 0 enables the interrupt output. While it is 0, the line stays inactive.
- R5: Configuration bit 1 selects the polarity: 1 is active high and 0 is active low. The polarity takes effect at once.
- R6: Configuration bit 2 selects open-drain. In that mode `irq_oe` is 1 only while the interrupt is active, and `irq_drv` carries the active level. In push-pull mode `irq_oe` is always 1 and `irq_drv` carries the line level.
- R7: When the logical interrupt goes inactive and configuration bits 15..8 hold N≠0, the line stays inactive for exactly N×16 clocks. It becomes active again on the next clock if an enabled source is still pending.
- R8: With configuration bits 15..8 equal to zero, the line may become active again on the clock after it becomes inactive.
- R9: Configuration bit 5 reads 1 exactly while a hold-off is running. Writes to it are ignored.
- R10: Writing a 1 to configuration bit 3 sets status bit 3. Bit 3 of the configuration register always reads 0.
- R11: `pme_irq` equals `pme_lvl` AND configuration bit 4, in the same cycle. It is not held off by the hold-off timer and does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, one register write per clock |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| dir_evt | input | 3 | Event pulses of the direct hardware sources |
| casc_lvl | input | 6 | Interrupt levels of the cascaded sub-modules |
| pme_lvl | input | 1 | Power-event request level |
| irq_drv | output | 1 | Value driven onto the interrupt line |
| irq_oe | output | 1 | Output enable of the interrupt line |
| pme_irq | output | 1 | Power-event interrupt output |

## Verification
The assertions assume that `dir_evt` and `casc_lvl` are synchronous to `clk` and that the register port makes at most one write per clock. They also assume that the hold-off field is not reprogrammed in the same cycle the line deasserts, or else that the reload uses the value held before the write. The stimulus changes every input shortly after a rising edge and issues writes one clock at a time. It reprograms the hold-off field only while the line is idle or active, never on the edge of a deassertion. It also varies the causes of deassertion (clear, mask, disable), so that each cause starts the hold-off.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NDIR     = 3,
  parameter int NCASC    = 6,
  parameter int HOLD_W   = 8,
  parameter int PRE_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [NDIR-1:0]  dir_evt,
  input  logic [NCASC-1:0] casc_lvl,
  input  logic        pme_lvl,
  output logic        irq_drv,
  output logic        irq_oe,
  output logic        pme_irq
);
  localparam int NSRC = NDIR + 1 + NCASC;
  localparam int CW   = HOLD_W + PRE_LOG2;

  logic [NDIR:0]      dir_q;
  logic [NSRC-1:0]    msk_q;
  logic               en_q, pol_q, od_q, pme_en_q, act_q;
  logic [HOLD_W-1:0]  deas_q;
  logic [CW-1:0]      hold_q;

  wire wr_sts = reg_wr && (reg_addr == 2'd0);
  wire wr_msk = reg_wr && (reg_addr == 2'd1);
  wire wr_cfg = reg_wr && (reg_addr == 2'd2);

  wire [NSRC-1:0] sts      = {casc_lvl, dir_q};
  wire            req      = |(sts & msk_q);
  wire            busy     = (hold_q != '0);
  wire            act_d    = en_q && req && (hold_q <= CW'(1));
  wire [CW-1:0]   hold_len = {deas_q, {PRE_LOG2{1'b0}}};
  wire [NDIR:0]   dir_clr  = wr_sts ? reg_wdata[NDIR:0] : '0;
  wire [NDIR:0]   dir_set  = {wr_cfg && reg_wdata[3], dir_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      msk_q    <= '0;
      en_q     <= 1'b0;
      pol_q    <= 1'b0;
      od_q     <= 1'b0;
      pme_en_q <= 1'b0;
      deas_q   <= '0;
      act_q    <= 1'b0;
      hold_q   <= '0;
    end else begin
      dir_q <= (dir_q & ~dir_clr) | dir_set;
      if (wr_msk) msk_q <= reg_wdata[NSRC-1:0];
      if (wr_cfg) begin
        en_q     <= reg_wdata[0];
        pol_q    <= reg_wdata[1];
        od_q     <= reg_wdata[2];
        pme_en_q <= reg_wdata[4];
        deas_q   <= reg_wdata[8 +: HOLD_W];
      end
      act_q <= act_d;
      if (act_q && !act_d) hold_q <= hold_len;
      else if (busy)       hold_q <= hold_q - CW'(1);
    end
  end

  assign irq_oe  = od_q ? act_q : 1'b1;
  assign irq_drv = od_q ? pol_q : ~(act_q ^ pol_q);
  assign pme_irq = pme_lvl & pme_en_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[NSRC-1:0] = sts;
      2'd1: reg_rdata[NSRC-1:0] = msk_q;
      2'd2: reg_rdata = {deas_q, 2'b00, busy, pme_en_q, 1'b0, od_q, pol_q, en_q};
      default: reg_rdata = '0;
    endcase
  end

  // R9: while the hold-off counter runs the line stays quiet
  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !act_q);
  // R7: a deassertion reloads the counter from the programmed field
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(act_q) && $past(deas_q) != '0) |-> (hold_q == {$past(deas_q), {PRE_LOG2{1'b0}}}));
  // R8: a zero field starts no hold-off
  a_r8_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(act_q) && $past(deas_q) == '0) |-> !busy);
  // R3, R4: activation needs an enabled pending source and the enable bit
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(req && en_q));
  // R1: sticky bits drop only through a status write
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_sts) |-> (($past(dir_q[NDIR-1:0]) & ~dir_q[NDIR-1:0]) == '0));
endmodule

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [2:0]  dir_evt = 3'b0;
  logic [5:0]  casc_lvl = 6'b0;
  logic        pme_lvl = 1'b0;
  logic        irq_drv, irq_oe, pme_irq;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  string phase = "R0";
  bit done = 1'b0;

  irq_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_evt(dir_evt),
    .casc_lvl(casc_lvl), .pme_lvl(pme_lvl), .irq_drv(irq_drv),
    .irq_oe(irq_oe), .pme_irq(pme_irq));

  always #5 clk = ~clk;

  // reference state
  int m_dir, m_msk, m_deas, m_need, m_low;
  bit m_en, m_pol, m_od, m_pme, m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_msk = 0; m_deas = 0; m_need = 0; m_low = 0;
      m_en = 0; m_pol = 0; m_od = 0; m_pme = 0; m_act = 0;
    end else begin
      int pend;
      bit ok, nxt;
      pend = (m_dir | (int'(casc_lvl) << 4)) & m_msk;
      ok   = (m_need == 0) || (m_low >= m_need);
      nxt  = m_en && (pend != 0) && ok;
      if (m_act && !nxt) begin m_need = m_deas * 16; m_low = 1; end
      else if (!nxt) m_low++;
      m_act = nxt;
      if (reg_wr && reg_addr == 2'd0) m_dir = m_dir & ~(int'(reg_wdata) & 15);
      m_dir = m_dir | int'(dir_evt);
      if (reg_wr && reg_addr == 2'd1) m_msk = int'(reg_wdata) & 10'h3ff;
      if (reg_wr && reg_addr == 2'd2) begin
        m_en = reg_wdata[0]; m_pol = reg_wdata[1]; m_od = reg_wdata[2];
        m_pme = reg_wdata[4]; m_deas = int'(reg_wdata[15:8]);
        if (reg_wdata[3]) m_dir = m_dir | 8;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_oe, e_drv, e_pme, busy;
      logic [15:0] e_rd;
      busy  = !m_act && m_need != 0 && m_low <= m_need;
      e_oe  = m_od ? m_act : 1'b1;
      e_drv = m_od ? m_pol : (m_pol ? m_act : !m_act);
      e_pme = pme_lvl && m_pme;
      case (reg_addr)
        2'd0: e_rd = 16'(m_dir | (int'(casc_lvl) << 4));
        2'd1: e_rd = 16'(m_msk);
        2'd2: e_rd = {8'(m_deas), 2'b00, busy, m_pme, 1'b0, m_od, m_pol, m_en};
        default: e_rd = 16'h0;
      endcase
      n_vec++;
      if (irq_oe !== e_oe || irq_drv !== e_drv || pme_irq !== e_pme || reg_rdata !== e_rd) begin
        n_bad++;
        $display("FAIL %s t=%0t oe/drv/pme/rd act=%b%b%b/%h exp=%b%b%b/%h",
                 phase, $time, irq_oe, irq_drv, pme_irq, reg_rdata, e_oe, e_drv, e_pme, e_rd);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(logic [2:0] v);
    dir_evt = v;
    step(1);
    dir_evt = 3'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", phase);
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    phase = "R0"; step(4);
    // R1: sticky direct bits, write-1-to-clear, set beats clear
    phase = "R1";
    wr(2'd1, 16'h3ff);
    wr(2'd2, 16'h0003);
    pulse(3'b001); step(3);
    wr(2'd0, 16'h0001); step(3);
    pulse(3'b110); step(2);
    reg_addr = 2'd0; reg_wdata = 16'h0006; reg_wr = 1'b1; dir_evt = 3'b010;
    step(1);
    reg_wr = 1'b0; dir_evt = 3'b0; step(3);
    wr(2'd0, 16'h000f); step(3);
    // R2: cascaded levels, not clearable by writes
    phase = "R2";
    casc_lvl = 6'b000100; step(3);
    wr(2'd0, 16'h03f0); step(3);
    casc_lvl = 6'b100001; step(2);
    casc_lvl = 6'b0; step(3);
    // R3: masking
    phase = "R3";
    wr(2'd1, 16'h0002);
    pulse(3'b001); step(3);
    pulse(3'b010); step(3);
    wr(2'd1, 16'h0000); step(3);
    wr(2'd1, 16'h3ff);
    wr(2'd0, 16'h000f); step(2);
    // R4: output enable
    phase = "R4";
    wr(2'd2, 16'h0002);
    pulse(3'b100); step(3);
    wr(2'd2, 16'h0003); step(3);
    wr(2'd2, 16'h0002); step(3);
    // R5: polarity
    phase = "R5";
    wr(2'd2, 16'h0001); step(3);
    wr(2'd2, 16'h0003); step(2);
    // R6: open drain in both polarities
    phase = "R6";
    wr(2'd2, 16'h0007); step(2);
    wr(2'd2, 16'h0005); step(2);
    wr(2'd0, 16'h000f); step(3);
    // R7: hold-off after clear, then re-pending source
    phase = "R7";
    wr(2'd2, 16'h0103);
    reg_addr = 2'd2;
    casc_lvl = 6'b000010; step(3);
    casc_lvl = 6'b0; step(1);
    casc_lvl = 6'b000010; step(30);
    // R7: hold-off triggered by masking, longer field
    wr(2'd2, 16'h0303);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h3ff); reg_addr = 2'd2; step(60);
    // R7: hold-off triggered by disabling, maximum field
    wr(2'd2, 16'hff03);
    wr(2'd2, 16'hff02);
    wr(2'd2, 16'hff03); reg_addr = 2'd2; step(4100);
    // R9: busy bit ignores writes, read during hold-off
    phase = "R9";
    wr(2'd2, 16'h0223);
    casc_lvl = 6'b0; step(2);
    wr(2'd2, 16'h0223); reg_addr = 2'd2; step(40);
    // R8: zero field, fast re-assertion
    phase = "R8";
    wr(2'd2, 16'h0003);
    casc_lvl = 6'b000010; step(3);
    casc_lvl = 6'b0; step(1);
    casc_lvl = 6'b000010; step(3);
    casc_lvl = 6'b0; step(3);
    // R10: software request
    phase = "R10";
    wr(2'd2, 16'h000b); reg_addr = 2'd0; step(3);
    wr(2'd0, 16'h0008); step(3);
    // R11: power event independent of hold-off
    phase = "R11";
    wr(2'd2, 16'h0413);
    pme_lvl = 1'b1; step(2);
    wr(2'd2, 16'h0403); step(2);
    wr(2'd2, 16'h0413);
    casc_lvl = 6'b010000; step(3);
    casc_lvl = 6'b0; reg_addr = 2'd2;
    pme_lvl = 1'b0; step(3);
    pme_lvl = 1'b1; step(5);
    casc_lvl = 6'b010000; step(80);
    pme_lvl = 1'b0; casc_lvl = 6'b0; step(5);
    finish_run();
  end
endmodule